// File: doc/BRIEF.md
# Tri-State Pad Output Controller

This block is the output half of an I/O cell, repeated for `W` pad bits. From core data and a 3-state control it forms three values per bit: the data placed on the pad driver, the driver enable, and the level the pad is seen to carry. Static configuration inputs choose several things. They set whether the data is inverted and how the 3-state control is read. They set whether data and enable go through flip-flops or straight through. They can turn the driver into an open-drain stage and switch on a bus-hold keeper. A single enable marks the pad as unused.

The two flip-flops share one clock, one clock enable and one synchronous reset. When the driver is released, the keeper supplies the last level that was actually driven. With the keeper off, a released pad reads as the parameter `FLOAT_LVL`, which stands for an external pull.

Top module: `pad_drive_ctrl`

## Requirements
- R1: With `cfg_inv`=1 the driven data is the bitwise complement of `core_d`. With `cfg_inv`=0 it equals `core_d`.
- R2: `cfg_tsense` decides how the enable is formed. Value 2'b00 releases a bit when its `core_t` is 1. Value 2'b01 releases it when `core_t` is 0. Values 2'b10 and 2'b11 enable every bit regardless of `core_t`.
- R3: With `cfg_dreg`=1, `pad_o` follows `core_d` (after inversion) one clock edge later. With `cfg_dreg`=0 it follows in the same cycle.
- R4: With `cfg_treg`=1 the enable takes effect one clock edge after `core_t` changes. With `cfg_treg`=0 it takes effect in the same cycle.
- R5: With `cfg_od`=1, `pad_o` is 0 on every bit. The pad is enabled exactly where the selected data is 0 and the enable path allows driving. It is never driven high.
- R6: With `cfg_keep`=1, a released bit reports in `pad_lvl` the last value it drove. The keeper captures only on edges where the bit is enabled and holds otherwise. It is 0 after reset.
- R7: With `cfg_keep`=0, a released bit reports `FLOAT_LVL` in `pad_lvl`. A driven bit always reports `pad_o`.
- R8: With `cfg_used`=0, every bit has `pad_oe`=0 and `pad_o`=0.
- R9: While `ce`=0 the data and 3-state flip-flops hold their contents.
- R10: The synchronous reset clears the data flip-flop to 0 and puts the 3-state flip-flop in the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both flip-flops and keeper |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for data and 3-state flip-flops |
| cfg_inv | input | 1 | Invert output data |
| cfg_tsense | input | 2 | 3-state control sense (00 high releases, 01 low releases, 1x always on) |
| cfg_dreg | input | 1 | Data taken from flip-flop when 1 |
| cfg_treg | input | 1 | Enable taken from flip-flop when 1 |
| cfg_od | input | 1 | Open-drain mode |
| cfg_keep | input | 1 | Bus-hold keeper on |
| cfg_used | input | 1 | Pad used; 0 releases all bits |
| core_d | input | W | Core output data |
| core_t | input | W | Core 3-state control |
| pad_o | output | W | Value presented to pad driver |
| pad_oe | output | W | Driver enable per bit |
| pad_lvl | output | W | Resolved pad level seen at the pin |

## Verification
The bench builds the block with `W`=4 and `FLOAT_LVL`=1. A float level of 1 is distinct from the keeper's reset value of 0, so a released bit in keeper mode can be told apart from an undriven bit without a keeper. Four bits are enough to drive mixed patterns in one step: some bits enabled, some released, some open-drain bits pulled low. This shows per-bit independence of the enable sense, the open-drain rerouting and the keeper capture.

// File: rtl/pad_drive_pkg.sv
package pad_drive_pkg;

  typedef enum logic [1:0] {
    TS_HIGH_RELEASES = 2'b00,
    TS_LOW_RELEASES  = 2'b01,
    TS_ALWAYS_ON     = 2'b10,
    TS_ALWAYS_ON_ALT = 2'b11
  } tsense_e;

  // Per-bit drive permission from the raw 3-state control
  function automatic logic f_enable(input logic t, input logic [1:0] sense);
    case (sense)
      TS_HIGH_RELEASES: f_enable = ~t;
      TS_LOW_RELEASES:  f_enable = t;
      default:          f_enable = 1'b1;
    endcase
  endfunction

  // Resolve driver value and enable: {oe, o}
  function automatic logic [1:0] f_drive(input logic d, input logic en,
                                         input logic od, input logic used);
    if (!used)   f_drive = 2'b00;
    else if (od) f_drive = {en & ~d, 1'b0};
    else         f_drive = {en, d};
  endfunction

endpackage

// File: rtl/pad_data_path.sv
module pad_data_path #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         cfg_inv,
  input  logic         cfg_dreg,
  input  logic [W-1:0] core_d,
  output logic [W-1:0] data_sel
);
  logic [W-1:0] d_eff;
  logic [W-1:0] data_q;

  assign d_eff = core_d ^ {W{cfg_inv}};

  always_ff @(posedge clk) begin
    if (rst)     data_q <= '0;
    else if (ce) data_q <= d_eff;
  end

  assign data_sel = cfg_dreg ? data_q : d_eff;
endmodule

// File: rtl/pad_enable_path.sv
module pad_enable_path
  import pad_drive_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [1:0]   cfg_tsense,
  input  logic         cfg_treg,
  input  logic [W-1:0] core_t,
  output logic [W-1:0] en_sel
);
  logic [W-1:0] en_raw;
  logic [W-1:0] en_q;

  for (genvar i = 0; i < W; i++) begin : g_en
    assign en_raw[i] = f_enable(core_t[i], cfg_tsense);
  end

  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (ce) en_q <= en_raw;
  end

  assign en_sel = cfg_treg ? en_q : en_raw;
endmodule

// File: rtl/pad_keeper.sv
module pad_keeper #(
  parameter int   W         = 4,
  parameter logic FLOAT_LVL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_keep,
  input  logic [W-1:0] drv_o,
  input  logic [W-1:0] drv_oe,
  output logic [W-1:0] lvl
);
  logic [W-1:0] hold_q;

  for (genvar i = 0; i < W; i++) begin : g_keep
    always_ff @(posedge clk) begin
      if (rst)            hold_q[i] <= 1'b0;
      else if (drv_oe[i]) hold_q[i] <= drv_o[i];
    end
    assign lvl[i] = drv_oe[i] ? drv_o[i] : (cfg_keep ? hold_q[i] : FLOAT_LVL);
  end
endmodule

// File: rtl/pad_drive_ctrl.sv
module pad_drive_ctrl
  import pad_drive_pkg::*;
#(
  parameter int   W         = 4,
  parameter logic FLOAT_LVL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         cfg_inv,
  input  logic [1:0]   cfg_tsense,
  input  logic         cfg_dreg,
  input  logic         cfg_treg,
  input  logic         cfg_od,
  input  logic         cfg_keep,
  input  logic         cfg_used,
  input  logic [W-1:0] core_d,
  input  logic [W-1:0] core_t,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_lvl
);
  logic [W-1:0] data_sel;
  logic [W-1:0] en_sel;

  pad_data_path #(.W(W)) u_data (
    .clk(clk), .rst(rst), .ce(ce), .cfg_inv(cfg_inv), .cfg_dreg(cfg_dreg),
    .core_d(core_d), .data_sel(data_sel)
  );

  pad_enable_path #(.W(W)) u_en (
    .clk(clk), .rst(rst), .ce(ce), .cfg_tsense(cfg_tsense), .cfg_treg(cfg_treg),
    .core_t(core_t), .en_sel(en_sel)
  );

  for (genvar i = 0; i < W; i++) begin : g_drv
    logic [1:0] res;
    assign res       = f_drive(data_sel[i], en_sel[i], cfg_od, cfg_used);
    assign pad_oe[i] = res[1];
    assign pad_o[i]  = res[0];
  end

  pad_keeper #(.W(W), .FLOAT_LVL(FLOAT_LVL)) u_keep (
    .clk(clk), .rst(rst), .cfg_keep(cfg_keep),
    .drv_o(pad_o), .drv_oe(pad_oe), .lvl(pad_lvl)
  );
endmodule

// File: rtl/pad_drive_chk.sv
module pad_drive_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic         cfg_inv,
  input logic [1:0]   cfg_tsense,
  input logic         cfg_dreg,
  input logic         cfg_treg,
  input logic         cfg_od,
  input logic         cfg_keep,
  input logic         cfg_used,
  input logic [W-1:0] pad_o,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_lvl
);
  logic [6:0] cfg_all;
  assign cfg_all = {cfg_inv, cfg_tsense, cfg_dreg, cfg_treg, cfg_od, cfg_used};

  a_r5_od_never_high: assert property (@(posedge clk) disable iff (rst)
    cfg_od |-> (pad_oe & pad_o) == '0);

  a_r8_unused_released: assert property (@(posedge clk) disable iff (rst)
    !cfg_used |-> (pad_oe == '0 && pad_o == '0));

  a_r2_always_on: assert property (@(posedge clk) disable iff (rst)
    (cfg_tsense[1] && !cfg_treg && !cfg_od && cfg_used) |-> pad_oe == '1);

  a_r6_keeper_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cfg_keep && pad_oe == '0 && $past(pad_oe) == '1)
      |-> pad_lvl == $past(pad_o));

  a_r9_ce_holds_data: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!ce) && cfg_dreg && !cfg_od && cfg_used && $stable(cfg_all))
      |-> $stable(pad_o));

  a_r10_tff_released: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cfg_treg && cfg_used && $stable(cfg_all)) |-> pad_oe == '0);
endmodule

bind pad_drive_ctrl pad_drive_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .cfg_inv(cfg_inv), .cfg_tsense(cfg_tsense),
  .cfg_dreg(cfg_dreg), .cfg_treg(cfg_treg), .cfg_od(cfg_od), .cfg_keep(cfg_keep),
  .cfg_used(cfg_used), .pad_o(pad_o), .pad_oe(pad_oe), .pad_lvl(pad_lvl)
);

// File: tb/pad_drive_ctrl_tb_top.sv
module pad_drive_ctrl_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst, ce, cfg_inv, cfg_dreg, cfg_treg, cfg_od, cfg_keep, cfg_used;
  logic [1:0] cfg_tsense;
  logic [W-1:0] core_d, core_t, pad_o, pad_oe, pad_lvl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pad_drive_ctrl #(.W(W), .FLOAT_LVL(1'b1)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .cfg_inv(cfg_inv), .cfg_tsense(cfg_tsense),
    .cfg_dreg(cfg_dreg), .cfg_treg(cfg_treg), .cfg_od(cfg_od), .cfg_keep(cfg_keep),
    .cfg_used(cfg_used), .core_d(core_d), .core_t(core_t),
    .pad_o(pad_o), .pad_oe(pad_oe), .pad_lvl(pad_lvl)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic settle(); #1; endtask

  task automatic set_plain();
    cfg_inv = 0; cfg_tsense = 2'b10; cfg_dreg = 0; cfg_treg = 0;
    cfg_od = 0; cfg_keep = 0; cfg_used = 1; ce = 1;
  endtask

  task automatic t_reset();
    rst = 1; set_plain(); cfg_dreg = 1; cfg_treg = 1; cfg_keep = 1;
    core_d = 4'b1111; core_t = 4'b0000;
    tick(); tick(); rst = 0; settle();
    chk("R10 oe after reset", pad_oe, 4'b0000);
    chk("R10 data ff after reset", pad_o, 4'b0000);
    chk("R6 keeper reset level", pad_lvl, 4'b0000);
  endtask

  task automatic t_invert();
    set_plain(); core_d = 4'b1010; settle();
    chk("R1 no invert", pad_o, 4'b1010);
    cfg_inv = 1; settle();
    chk("R1 invert", pad_o, 4'b0101);
    chk("R7 driven level follows pad_o", pad_lvl, 4'b0101);
  endtask

  task automatic t_sense();
    set_plain(); core_t = 4'b0011;
    cfg_tsense = 2'b00; settle(); chk("R2 high releases", pad_oe, 4'b1100);
    cfg_tsense = 2'b01; settle(); chk("R2 low releases", pad_oe, 4'b0011);
    cfg_tsense = 2'b11; settle(); chk("R2 always on", pad_oe, 4'b1111);
  endtask

  task automatic t_dreg();
    set_plain(); core_d = 4'b0000; tick();
    cfg_dreg = 1; core_d = 4'b0110; settle();
    chk("R3 registered before edge", pad_o, 4'b0000);
    tick();
    chk("R3 registered after edge", pad_o, 4'b0110);
  endtask

  task automatic t_treg();
    set_plain(); cfg_tsense = 2'b00; core_t = 4'b1111; tick();
    cfg_treg = 1; core_t = 4'b1000; settle();
    chk("R4 registered enable before edge", pad_oe, 4'b0000);
    tick();
    chk("R4 registered enable after edge", pad_oe, 4'b0111);
    cfg_treg = 0; core_t = 4'b0001; settle();
    chk("R4 direct enable", pad_oe, 4'b1110);
  endtask

  task automatic t_ce();
    set_plain(); cfg_dreg = 1; cfg_treg = 1; cfg_tsense = 2'b00;
    core_d = 4'b1100; core_t = 4'b0000; tick();
    ce = 0; core_d = 4'b0011; core_t = 4'b1111; tick(); tick();
    chk("R9 data held", pad_o, 4'b1100);
    chk("R9 enable held", pad_oe, 4'b1111);
    ce = 1; tick();
    chk("R9 data after ce", pad_o, 4'b0011);
  endtask

  task automatic t_od();
    set_plain(); cfg_od = 1; core_d = 4'b0101; settle();
    chk("R5 od pad_o", pad_o, 4'b0000);
    chk("R5 od enable", pad_oe, 4'b1010);
    chk("R7 od float level", pad_lvl, 4'b0101);
    cfg_tsense = 2'b00; core_t = 4'b1000; settle();
    chk("R5 od gated by tsense", pad_oe, 4'b0010);
  endtask

  task automatic t_keep();
    set_plain(); cfg_keep = 1; core_d = 4'b1001; tick();
    cfg_tsense = 2'b00; core_t = 4'b1111; core_d = 4'b0110; settle();
    chk("R6 released keeps last", pad_lvl, 4'b1001);
    tick(); tick();
    chk("R6 no capture while released", pad_lvl, 4'b1001);
    core_t = 4'b1100; tick();
    core_t = 4'b1111; settle();
    chk("R6 partial capture", pad_lvl, 4'b1010);
  endtask

  task automatic t_float();
    set_plain(); cfg_tsense = 2'b00; core_t = 4'b1111; settle();
    chk("R7 float level", pad_lvl, 4'b1111);
  endtask

  task automatic t_unused();
    set_plain(); core_d = 4'b1111; cfg_used = 0; settle();
    chk("R8 unused oe", pad_oe, 4'b0000);
    chk("R8 unused data", pad_o, 4'b0000);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset(); t_invert(); t_sense(); t_dreg(); t_treg();
    t_ce(); t_od(); t_keep(); t_float(); t_unused();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule